// File: doc/BRIEF.md
# Audio Master Clock Ratio Detector

This block runs on an audio converter's master clock and watches the left/right frame clock and the bit clock. It works out whether the master clock is 256 or 384 times the sample rate, with no configuration input. The sample rate is set by the frame clock, typically 32, 44.1 or 48 kHz. It does this by counting master clock cycles between rising frame clock edges. A change of result takes effect only after two frames agree.

An internal frame counter runs on the master clock, modulo the detected ratio. Each rising frame clock edge should arrive when that counter is at zero. Any other position is a phase offset, folded to a signed distance and expressed in bit clock periods. The bit clock period is measured in master clock cycles. Offsets up to six bit clocks either way are tolerated. A larger offset makes the block restart its counter on the frame edge. It then requests that the converter output be held at midscale until a later frame edge lands in tolerance.

The outputs are the detected ratio, a locked flag and the midscale request. The midscale request is asserted whenever the block is not locked, including the whole time from reset until the first ratio decision and alignment.

Top module: `mclk_ratio_detector`

## Requirements
- R1: While rst_ni is low and right after it is released, locked_o is 0, force_mid_o is 1 and ratio_384_o is 0.
- R2: A frame period is the number of master clock cycles from one rising lrck_i edge to the next. A period of 256±2 classifies as 256x (ratio_384_o = 0), 384±2 as 384x (ratio_384_o = 1), anything else as invalid. The first rising edge after reset only starts the count.
- R3: ratio_384_o and the ratio-valid state change only when two consecutive frame periods give the same class. One differing frame leaves ratio_384_o and locked_o unchanged.
- R4: Two consecutive invalid frame periods clear locked_o, and ratio_384_o keeps its last value.
- R5: If 1023 master clock cycles pass with no rising lrck_i edge, locked_o drops to 0 before the next edge arrives.
- R6: The bit clock period is the number of master clock cycles between consecutive rising bck_i edges. It sets the bit clock unit used for the phase offset.
- R7: At each rising lrck_i edge the counter position p (0 at exact alignment) gives an offset of p if p is below half the ratio, and ratio−p otherwise. An offset whose whole number of bit clock periods is at most 6 keeps the block aligned, with no realignment, in either direction.
- R8: An offset of 7 or more whole bit clock periods, or a frame edge seen while the ratio or bit clock period is not yet valid, restarts the counter on that edge. The block is then unaligned (locked_o = 0, force_mid_o = 1) from the next cycle. A later edge within tolerance aligns it again.
- R9: locked_o is 1 exactly when the ratio is valid and the block is aligned, and force_mid_o is its inverse. Both change only in the cycle after a rising lrck_i edge, except for the drop of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lrck_i | input | 1 | Frame (left/right) clock, synchronous to clk_i |
| bck_i | input | 1 | Bit clock, synchronous to clk_i |
| ratio_384_o | output | 1 | Detected ratio: 1 for 384x, 0 for 256x |
| locked_o | output | 1 | Ratio valid and frame clock aligned |
| force_mid_o | output | 1 | Request to hold the converter output at midscale |

## Verification
The frame clock is driven at both ratios, each with the matching bit clock period (4 or 6 cycles). These runs separate the two classes and the switch-over delay of two frames. Single frames are lengthened or shortened by amounts on either side of the threshold: 27/28 cycles at 256x and 41/42 cycles at 384x, in both directions. These show that the limit scales with the measured bit clock and that a single odd frame changes neither the ratio nor the lock. Two consecutive bad frames and a long frame clock stall are applied to tell the loss-of-ratio paths apart from the one-frame glitch filter. Each time, the recovery sequence back to lock is followed.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_LO   = 2'd1,
    CLS_HI   = 2'd2
  } ratio_cls_e;
endpackage

// File: rtl/mrd_edge_det.sv
module mrd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/mrd_frame_ratio_meter.sv
module mrd_frame_ratio_meter
  import mclk_ratio_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int RATIO_LO = 256,
  parameter int RATIO_HI = 384,
  parameter int TOL      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_rise_i,
  output logic valid_o,
  output logic ratio_hi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  ratio_cls_e       cand_q, cls;
  logic             valid_q, ratio_hi_q;

  function automatic ratio_cls_e classify(input logic [CNT_W-1:0] n);
    int c;
    c = int'(n);
    if (c >= RATIO_LO - TOL && c <= RATIO_LO + TOL)      return CLS_LO;
    else if (c >= RATIO_HI - TOL && c <= RATIO_HI + TOL) return CLS_HI;
    else                                                 return CLS_NONE;
  endfunction

  always_comb cls = classify(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      seen_q     <= 1'b0;
      cand_q     <= CLS_NONE;
      valid_q    <= 1'b0;
      ratio_hi_q <= 1'b0;
    end else if (frame_rise_i) begin
      cnt_q <= CNT_W'(1);
      if (!seen_q) begin
        seen_q <= 1'b1;
      end else begin
        cand_q <= cls;
        if (cls == cand_q) begin
          if (cls == CLS_NONE) begin
            valid_q <= 1'b0;
          end else begin
            valid_q    <= 1'b1;
            ratio_hi_q <= (cls == CLS_HI);
          end
        end
      end
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      // frame clock stalled
      valid_q <= 1'b0;
      cand_q  <= CLS_NONE;
    end
  end

  assign valid_o    = valid_q;
  assign ratio_hi_o = ratio_hi_q;

  assert_ratio_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_rise_i |=> $stable(ratio_hi_q));

  assert_stall_unlock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !frame_rise_i) |=> !valid_q);
endmodule

// File: rtl/mrd_bclk_period_meter.sv
module mrd_bclk_period_meter #(
  parameter int PER_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_rise_i,
  output logic [PER_W-1:0] per_o,
  output logic             valid_o
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] cnt_q, per_q;
  logic             seen_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (bit_rise_i) begin
      cnt_q <= PER_W'(1);
      if (seen_q) begin
        per_q   <= cnt_q;
        valid_q <= 1'b1;
      end else begin
        seen_q <= 1'b1;
      end
    end else if (cnt_q != PER_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign per_o   = per_q;
  assign valid_o = valid_q;

  assert_period_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_rise_i && seen_q) |=> (per_q == $past(cnt_q)));
endmodule

// File: rtl/mrd_phase_tracker.sv
module mrd_phase_tracker #(
  parameter int POS_W    = 9,
  parameter int RATIO_LO = 256,
  parameter int RATIO_HI = 384,
  parameter int PER_W    = 5,
  parameter int LIMIT    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_rise_i,
  input  logic             ratio_valid_i,
  input  logic             ratio_hi_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             per_valid_i,
  output logic             aligned_o
);
  localparam int MOD_W = POS_W + 1;
  localparam int MUL_W = PER_W + $clog2(LIMIT + 2);
  localparam int CMP_W = (MOD_W > MUL_W) ? MOD_W : MUL_W;

  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             aligned_q;
  logic [MOD_W-1:0] modulus, half, pos_x, mag;
  logic [CMP_W-1:0] thr, mag_c;
  logic             ok;

  always_comb begin
    modulus = ratio_hi_i ? MOD_W'(RATIO_HI) : MOD_W'(RATIO_LO);
    half    = modulus >> 1;
    pos_x   = {1'b0, pos_q};
    // fold position to distance from frame start
    if (pos_x < half)         mag = pos_x;
    else if (pos_x < modulus) mag = modulus - pos_x;
    else                      mag = modulus;
    thr     = CMP_W'(LIMIT + 1) * CMP_W'(per_i);
    mag_c   = CMP_W'(mag);
    ok      = ratio_valid_i & per_valid_i & (mag_c < thr);
    pos_nxt = (pos_x >= modulus - MOD_W'(1)) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else if (frame_rise_i) begin
      aligned_q <= ok;
      pos_q     <= ok ? pos_nxt : POS_W'(1);
    end else begin
      pos_q <= pos_nxt;
    end
  end

  assign aligned_o = aligned_q;

  assert_realign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_rise_i && !ok) |=> (pos_q == POS_W'(1) && !aligned_q));

  assert_tolerate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_rise_i && ok) |=> aligned_q);
endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector #(
  parameter int CNT_W    = 10,
  parameter int RATIO_LO = 256,
  parameter int RATIO_HI = 384,
  parameter int TOL      = 2,
  parameter int PER_W    = 5,
  parameter int LIMIT    = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  input  logic bck_i,
  output logic ratio_384_o,
  output logic locked_o,
  output logic force_mid_o
);
  localparam int POS_W = $clog2(RATIO_HI);

  logic [1:0]       raw_w, rise_w;
  logic             frame_rise, bit_rise;
  logic             ratio_valid, ratio_hi, per_valid, aligned;
  logic [PER_W-1:0] per;

  assign raw_w = {bck_i, lrck_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_edge
    mrd_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (raw_w[gi]),
      .rise_o (rise_w[gi])
    );
  end

  assign frame_rise = rise_w[0];
  assign bit_rise   = rise_w[1];

  mrd_frame_ratio_meter #(
    .CNT_W(CNT_W), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .TOL(TOL)
  ) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_rise_i (frame_rise),
    .valid_o      (ratio_valid),
    .ratio_hi_o   (ratio_hi)
  );

  mrd_bclk_period_meter #(.PER_W(PER_W)) u_bper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_rise_i (bit_rise),
    .per_o      (per),
    .valid_o    (per_valid)
  );

  mrd_phase_tracker #(
    .POS_W(POS_W), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI),
    .PER_W(PER_W), .LIMIT(LIMIT)
  ) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_rise_i  (frame_rise),
    .ratio_valid_i (ratio_valid),
    .ratio_hi_i    (ratio_hi),
    .per_i         (per),
    .per_valid_i   (per_valid),
    .aligned_o     (aligned)
  );

  assign ratio_384_o = ratio_hi;
  assign locked_o    = ratio_valid & aligned;
  assign force_mid_o = ~locked_o;

  assert_lock_on_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(frame_rise));
endmodule

// File: tb/tb_mclk_ratio_detector.sv
module tb_mclk_ratio_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic bck = 1'b0;
  logic ratio_384, locked, force_mid;

  int n_checks = 0;
  int n_fail = 0;
  int g = 0;
  int tb_per = 4;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mclk_ratio_detector dut (
    .clk_i(clk), .rst_ni(rst_n), .lrck_i(lrck), .bck_i(bck),
    .ratio_384_o(ratio_384), .locked_o(locked), .force_mid_o(force_mid)
  );

  // behavioural reference, class codes: 0 invalid, 1 = 256x, 2 = 384x
  int m_lrq = 0, m_bq = 0, m_cnt = 0, m_seen = 0, m_cand = 0;
  int m_valid = 0, m_ratio = 0, m_bcnt = 0, m_bper = 0, m_bseen = 0;
  int m_bvalid = 0, m_pos = 0, m_aligned = 0;

  function automatic int cls_of(int c);
    if (c >= 254 && c <= 258) return 1;
    if (c >= 382 && c <= 386) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int lr_r, b_r, md, mag, okf, cl;
    int n_pos, n_al, n_cnt, n_seen, n_cand, n_valid, n_ratio;
    int n_bcnt, n_bper, n_bseen, n_bvalid;
    if (!rst_n) begin
      m_lrq = 0; m_bq = 0; m_cnt = 0; m_seen = 0; m_cand = 0;
      m_valid = 0; m_ratio = 0; m_bcnt = 0; m_bper = 0; m_bseen = 0;
      m_bvalid = 0; m_pos = 0; m_aligned = 0;
    end else begin
      lr_r = (lrck && m_lrq == 0) ? 1 : 0;
      b_r  = (bck && m_bq == 0) ? 1 : 0;
      md = m_ratio ? 384 : 256;
      n_pos = (m_pos >= md - 1) ? 0 : m_pos + 1;
      n_al = m_aligned;
      if (lr_r) begin
        if (m_pos < md / 2) mag = m_pos;
        else if (m_pos < md) mag = md - m_pos;
        else mag = md;
        okf = (m_valid && m_bvalid && mag < 7 * m_bper) ? 1 : 0;
        n_al = okf;
        if (!okf) n_pos = 1;
      end
      n_cnt = m_cnt; n_seen = m_seen; n_cand = m_cand;
      n_valid = m_valid; n_ratio = m_ratio;
      if (lr_r) begin
        n_cnt = 1;
        if (!m_seen) n_seen = 1;
        else begin
          cl = cls_of(m_cnt);
          if (cl == m_cand) begin
            if (cl == 0) n_valid = 0;
            else begin n_valid = 1; n_ratio = (cl == 2) ? 1 : 0; end
          end
          n_cand = cl;
        end
      end else if (m_cnt != 1023) n_cnt = m_cnt + 1;
      else begin n_valid = 0; n_cand = 0; end
      n_bcnt = m_bcnt; n_bper = m_bper; n_bseen = m_bseen; n_bvalid = m_bvalid;
      if (b_r) begin
        n_bcnt = 1;
        if (m_bseen) begin n_bper = m_bcnt; n_bvalid = 1; end
        else n_bseen = 1;
      end else if (m_bcnt != 31) n_bcnt = m_bcnt + 1;
      m_pos = n_pos; m_aligned = n_al; m_cnt = n_cnt; m_seen = n_seen;
      m_cand = n_cand; m_valid = n_valid; m_ratio = n_ratio;
      m_bcnt = n_bcnt; m_bper = n_bper; m_bseen = n_bseen; m_bvalid = n_bvalid;
      m_lrq = lrck; m_bq = bck;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, g);
    end
  endtask

  task automatic compare_model();
    int ml;
    ml = (m_valid && m_aligned) ? 1 : 0;
    check("R2 ratio vs model", int'(ratio_384), m_ratio);
    check("R9 locked vs model", int'(locked), ml);
    check("R9 force_mid vs model", int'(force_mid), 1 - ml);
  endtask

  task automatic cyc(input logic lr);
    @(negedge clk);
    compare_model();
    lrck = lr;
    bck = ((g % tb_per) < tb_per / 2);
    g++;
  endtask

  task automatic frame(input int len);
    for (int i = 0; i < len; i++) cyc(i < len / 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset locked", int'(locked), 0);
    check("R1 reset force_mid", int'(force_mid), 1);
    check("R1 reset ratio", int'(ratio_384), 0);
    rst_n = 1'b1;
    repeat (6) cyc(1'b0);
    check("R1 after release locked", int'(locked), 0);

    // 256x acquisition
    frame(256); frame(256); frame(256);
    check("R9 not aligned yet force_mid", int'(force_mid), 1);
    check("R9 not aligned yet locked", int'(locked), 0);
    frame(256);
    check("R2 256x locked", int'(locked), 1);
    check("R2 256x ratio", int'(ratio_384), 0);
    frame(256);

    frame(258); frame(256);
    check("R2 tolerance 258 locked", int'(locked), 1);
    frame(259); frame(256);
    check("R3 single bad frame locked", int'(locked), 1);
    check("R3 single bad frame ratio", int'(ratio_384), 0);
    frame(256);

    // positive phase offset, limit 28 cycles at 4-cycle bit clock
    frame(278); frame(256);
    check("R7 offset +27 tolerated", int'(locked), 1);
    frame(257); frame(256);
    check("R8 offset +28 realign locked", int'(locked), 0);
    check("R8 offset +28 force_mid", int'(force_mid), 1);
    frame(256);
    check("R8 realigned relock", int'(locked), 1);

    // negative phase offset
    frame(229); frame(256);
    check("R7 offset -27 tolerated", int'(locked), 1);
    frame(255); frame(256);
    check("R8 offset -28 realign", int'(locked), 0);
    frame(256);
    check("R8 relock after -28", int'(locked), 1);

    // switch to 384x with 6-cycle bit clock
    tb_per = 6;
    frame(384);
    check("R3 first 384 frame ratio kept", int'(ratio_384), 0);
    frame(384);
    check("R3 one 384 period ratio kept", int'(ratio_384), 0);
    frame(384);
    check("R2 384x ratio", int'(ratio_384), 1);
    check("R8 counter modulus realign", int'(locked), 0);
    frame(384);
    check("R2 384x locked", int'(locked), 1);

    frame(425); frame(384);
    check("R6 offset +41 tolerated at 6-cycle bit clock", int'(locked), 1);
    frame(343); frame(384);
    check("R7 offset back to 0", int'(locked), 1);
    frame(426); frame(384);
    check("R6 offset +42 realign", int'(locked), 0);
    frame(384);
    check("R8 relock at 384x", int'(locked), 1);

    // two consecutive bad frames
    frame(300); frame(300); frame(384);
    check("R4 two bad frames locked", int'(locked), 0);
    check("R4 ratio held", int'(ratio_384), 1);
    frame(384); frame(384);
    check("R4 recovering not yet locked", int'(locked), 0);
    frame(384);
    check("R4 recovered", int'(locked), 1);

    // frame clock stall
    frame(1100);
    check("R5 stall unlock", int'(locked), 0);
    check("R5 stall ratio held", int'(ratio_384), 1);
    frame(384); frame(384); frame(384);
    check("R5 recovering", int'(locked), 0);
    frame(384);
    check("R5 recovered", int'(locked), 1);
    frame(384);

    finish_run();
  end
endmodule